// File: doc/BRIEF.md
# Preamble Interval Window Detector

This block watches a sliced one-bit data stream and decides whether it carries a preamble. An external sample enable marks the cycles of the slow internal sample clock. The block counts those sample cycles between successive transitions of the data bit. Each measured interval is compared against a programmable window centred on a 9-bit target count, with a 7-bit tolerance applied both above and below. The target is normally twice the sample-clock rate divided by the preamble tone frequency, rounded. For example, a 23.69 kHz sample clock and a 600 Hz preamble give 79.

Each interval that falls inside the window produces a one-cycle match strobe. After a run of consecutive matches of configurable length, the block raises a detected flag. The flag stays high until the enable input is cleared, and downstream logic may use it to open the data path or to hold a receive window. Clearing the enable returns every piece of state to idle.

Top module: `preamble_window_det`

## Requirements
- R1: An interval is the number of cycles with `tick` high from one data transition to the next. A transition is seen when `din` differs from the value it had at the previous tick. Clock cycles with `tick` low neither count nor detect transitions.
- R2: An evaluated interval N matches when max(0, target-margin) <= N <= target+margin, with both bounds inclusive. Each match drives `match_stb` high for exactly one clock, in the cycle after the clock edge at which the closing transition was sampled. Intervals outside the window produce no strobe.
- R3: The interval counter saturates at 511 and never wraps. An interval longer than 511 ticks is measured as 511.
- R4: The lower bound is computed without underflow. When margin exceeds target, the lower bound is 0. For example, target 5 with margin 20 accepts an interval of 1.
- R5: `detected` rises after RUN_LEN consecutive matching intervals (default 4). It rises in the same cycle as the strobe of the last of those intervals, and three consecutive matches alone do not raise it.
- R6: A non-matching interval clears the run of consecutive matches, so RUN_LEN fresh matches are needed afterwards.
- R7: Once high, `detected` stays high while `det_en` remains high, whatever intervals follow.
- R8: While `det_en` is low, the interval counter, the run count and `detected` are cleared synchronously, and no strobe is produced.
- R9: The first transition after `det_en` rises, or after reset, only starts timing. It is not evaluated and gives no strobe.
- R10: After reset, `detected` and `match_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-clock enable, one cycle per internal sample |
| din | input | 1 | Sliced demodulated data bit |
| det_en | input | 1 | Detection enable; low clears all state |
| target | input | 9 | Expected interval length in ticks |
| margin | input | 7 | Symmetric tolerance around the target |
| detected | output | 1 | Sticky preamble-detected flag |
| match_stb | output | 1 | One-cycle pulse per matching interval |

## Verification
The hardest situation to reach is a run of matches broken at the edge of the window. This needs intervals exactly at target±margin and one tick outside it, placed so that a single miss lands between three matches and the completing fourth. The stimulus drives whole intervals by tick count, spaces the ticks with idle clock cycles, and pushes a predicted strobe for every interval it expects to match, together with the flag value expected with that strobe. The clamped lower bound and the saturated count are reached with dedicated targets of 5 and 511, the latter using an interval of 600 ticks.

// File: rtl/preamble_window_det.sv
module preamble_window_det #(
  parameter int CNT_W   = 9,
  parameter int MARG_W  = 7,
  parameter int RUN_LEN = 4,
  localparam int RUN_W  = $clog2(RUN_LEN + 1),
  localparam int WIDE_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              din,
  input  logic              det_en,
  input  logic [CNT_W-1:0]  target,
  input  logic [MARG_W-1:0] margin,
  output logic              detected,
  output logic              match_stb
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             din_q;
  logic             armed;
  logic             stb_q;
  logic             det_q;
  logic [CNT_W-1:0] cnt;
  logic [RUN_W-1:0] run;

  wire              edge_ev = tick && (din != din_q);
  wire [CNT_W-1:0]  meas    = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);

  wire signed [WIDE_W-1:0] meas_w = {2'b00, meas};
  wire signed [WIDE_W-1:0] tgt_w  = {2'b00, target};
  wire signed [WIDE_W-1:0] mrg_w  = {{(WIDE_W-MARG_W){1'b0}}, margin};
  wire signed [WIDE_W-1:0] lo_w   = tgt_w - mrg_w;
  wire signed [WIDE_W-1:0] hi_w   = tgt_w + mrg_w;
  wire                     in_win = (meas_w >= lo_w) && (meas_w <= hi_w);

  wire eval = det_en && armed && edge_ev;
  wire hit  = eval && in_win;
  wire miss = eval && !in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      armed <= 1'b0;
      stb_q <= 1'b0;
      det_q <= 1'b0;
      cnt   <= '0;
      run   <= '0;
    end else begin
      stb_q <= hit;
      if (tick) din_q <= din;
      if (!det_en) begin
        armed <= 1'b0;
        det_q <= 1'b0;
        cnt   <= '0;
        run   <= '0;
      end else if (tick) begin
        if (edge_ev) begin
          cnt   <= '0;
          armed <= 1'b1;
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + CNT_W'(1);
        end
        if (hit) begin
          if (run != RUN_W'(RUN_LEN)) run <= run + RUN_W'(1);
          if (run >= RUN_W'(RUN_LEN - 1)) det_q <= 1'b1;
        end else if (miss) begin
          run <= '0;
        end
      end
    end
  end

  assign match_stb = stb_q;
  assign detected  = det_q;

endmodule

// File: rtl/preamble_window_det_chk.sv
module preamble_window_det_chk #(
  parameter int CNT_W   = 9,
  parameter int RUN_LEN = 4,
  localparam int RUN_W  = $clog2(RUN_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             det_en,
  input logic             detected,
  input logic             match_stb,
  input logic [CNT_W-1:0] cnt,
  input logic [RUN_W-1:0] run
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |-> ($past(tick) && $past(det_en))); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0)); // R3
  AST_DET_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detected) |-> match_stb); // R5
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(RUN_LEN)); // R6
  AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (detected && det_en) |=> detected); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!detected && !match_stb && run == '0 && cnt == '0)); // R8

endmodule

bind preamble_window_det preamble_window_det_chk #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .det_en(det_en),
  .detected(detected), .match_stb(match_stb), .cnt(cnt), .run(run)
);

// File: tb/sim_preamble_window_det.sv
module sim_preamble_window_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       din = 1'b0;
  logic       det_en = 1'b0;
  logic [8:0] target = 9'd79;
  logic [6:0] margin = 7'd3;
  logic       detected, match_stb;

  int checks = 0, failures = 0;
  bit done = 0;
  bit    q_det[$];
  string q_req[$];
  int exp_stb = 0, got_stb = 0;

  bit m_en = 0, m_armed = 0, m_det = 0;
  int m_run = 0;
  int gap = 1;

  always #4 clk = ~clk;

  preamble_window_det u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .din(din),
    .det_en(det_en), .target(target), .margin(margin),
    .detected(detected), .match_stb(match_stb));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && match_stb) begin
      got_stb++;
      if (q_det.size() == 0) begin
        check(0, "R2 unexpected strobe", 1, 0);
      end else begin
        bit e;
        string r;
        e = q_det.pop_front();
        r = q_req.pop_front();
        check(detected == e, r, detected, e);
      end
    end
  end

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic interval(int n, string req);
    int m, lo, hi;
    m  = (n > 511) ? 511 : n;
    lo = int'(target) - int'(margin);
    if (lo < 0) lo = 0;
    hi = int'(target) + int'(margin);
    repeat (n - 1) do_tick();
    if (m_en && m_armed) begin
      if (m >= lo && m <= hi) begin
        if (m_run < 4) m_run++;
        if (m_run >= 4) m_det = 1;
        q_det.push_back(m_det);
        q_req.push_back(req);
        exp_stb++;
      end else begin
        m_run = 0;
      end
    end
    if (m_en) m_armed = 1;
    din = ~din;
    do_tick();
  endtask

  task automatic set_en(bit v);
    @(negedge clk) det_en = v;
    m_en = v;
    if (!v) begin m_armed = 0; m_run = 0; m_det = 0; end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(detected == 0, "R10 detected", detected, 0);
    check(match_stb == 0, "R10 match_stb", match_stb, 0);

    set_en(1);
    interval(40, "R9 first edge");
    interval(79, "R2 centre");
    interval(76, "R2 low bound");
    gap = 3;
    interval(82, "R1 high bound spaced ticks");
    check(detected == 0, "R5 three matches", detected, 0);
    interval(75, "R2 below window");
    interval(80, "R6 after miss");
    interval(83, "R2 above window");
    interval(78, "R6 run 1");
    interval(77, "R6 run 2");
    interval(79, "R6 run 3");
    interval(80, "R5 fourth match");
    check(detected == 1, "R5 detected after four", detected, 1);
    interval(200, "R7 long miss");
    interval(10, "R7 short miss");
    check(detected == 1, "R7 sticky", detected, 1);

    gap = 1;
    set_en(0);
    check(detected == 0, "R8 clear on disable", detected, 0);
    interval(79, "R8 disabled");
    interval(79, "R8 disabled");
    check(detected == 0, "R8 still clear", detected, 0);

    target = 9'd5;
    margin = 7'd20;
    set_en(1);
    interval(3, "R9 arm again");
    interval(1, "R4 clamped low");
    interval(2, "R4 small");
    interval(25, "R4 high bound");
    interval(26, "R4 above");
    check(detected == 0, "R6 miss before fourth", detected, 0);

    set_en(0);
    target = 9'd511;
    margin = 7'd0;
    set_en(1);
    interval(4, "R9 arm");
    interval(600, "R3 saturated");
    interval(510, "R3 one short");
    interval(511, "R3 exact");

    repeat (4) @(negedge clk);
    check(q_det.size() == 0, "R2 pending strobes", q_det.size(), 0);
    check(got_stb == exp_stb, "R2 strobe count", got_stb, exp_stb);
    finish_run();
  end
endmodule